// File: doc/BRIEF.md
# Multi-Rail Power Sequencing Controller

This block is the digital core of a supervisor that brings up to three supply rails onto a load in a fixed order. Analog comparators outside the block report, per rail, whether the input supply is present, whether it is above its undervoltage level, whether the switched output has reached its power-good level and whether it has decayed below its power-low level. Two further flags describe a shared enable line, one above the rising threshold and one below the falling threshold. A ramp tracker adds a fault pulse. Every flag passes through a two-flop synchronizer before the state machine uses it, so any input change takes effect at the third rising clock edge after it is applied.

Once the start conditions hold, the controller waits a programmable delay before each rail. It then turns on that rail's gate and holds until the rail reports power-good. When every included rail is up, it raises the power-good output after a further timeout. A fault timer bounds the whole sequence. Every fault leads to a retry hold with strong gate pulldown and output discharge on all rails, followed by a fresh start attempt. Dropping the enable either tracks all rails down together or, before power-good is reached, forces a fast shutdown.

States: `ST_IDLE`, `ST_START_DELAY` (delay before rail n), `ST_RAMP_RAIL` (rail n switched on, awaiting its good flag), `ST_ALL_UP`, `ST_TRACK_DOWN`, `ST_FAST_SHUTDOWN`, `ST_RETRY_HOLD`. Transitions are IDLE→START_DELAY (start accepted, at least one rail included) or IDLE→ALL_UP (no rail included). START_DELAY→RAMP_RAIL happens when the delay expires. RAMP_RAIL→START_DELAY happens on good when another included rail remains, and RAMP_RAIL→ALL_UP on good when none remains. START_DELAY/RAMP_RAIL/ALL_UP→RETRY_HOLD happens on a fault: tracker pulse, undervoltage, fault timer expiry, or loss of good in ALL_UP. START_DELAY/RAMP_RAIL/ALL_UP→FAST_SHUTDOWN happens when the enable falls before power-good. ALL_UP→TRACK_DOWN happens when the enable falls after power-good. TRACK_DOWN→RETRY_HOLD happens on a tracker pulse. TRACK_DOWN/FAST_SHUTDOWN→IDLE happens when all outputs are low. RETRY_HOLD→IDLE happens when the retry period ends.

Top module: `rail_seq_ctrl`

## Requirements
- R1: A start is accepted from idle only while the enable-high flag is 1, the enable-low flag is 0, every `supply_ok` bit is 1 (excluded rails included) and every included rail's `out_low` is 1; otherwise no gate turns on.
- R2: Gates turn on strictly in ascending rail order (bit 0 first), at most one per cycle, and earlier gates stay on while later rails are sequenced.
- R3: Each included rail's gate rises DELAY_CYC+3 cycles after the input change that enables it (start conditions for the first rail), covering the two synchronizer stages and the delay.
- R4: A rail's power-up ends when its `out_good` bit is 1; the next included rail's delay then begins, and its gate rises DELAY_CYC+3 cycles after that `out_good` change.
- R5: A rail with `supply_here` = 0 is excluded: it is skipped without a delay, its gate stays 0, and it counts as good and low.
- R6: If sequencing has not reached ALL_UP within FAULT_CYC cycles of the start, all gates go off and the retry hold begins (FAULT_CYC+3 cycles after the start input change).
- R7: The retry hold drives `gate_sink` and `out_drain` to all ones for 16×FAULT_CYC cycles; the controller then returns to idle and restarts (first gate DELAY_CYC+1 cycles later) only if the R1 conditions, including all outputs low, hold.
- R8: `power_good` rises PG_CYC+2 cycles after the last included rail's `out_good` change (or after the start input change when no rail is included) and is 1 only while every included gate is on.
- R9: The enable-low flag before `power_good` is reached forces a fast shutdown: all gates off and `gate_sink`/`out_drain` all ones, until every included output is low, then idle.
- R10: The enable-low flag after `power_good` tracks the rails down: gates off with `gate_sink` and `out_drain` at 0 and `power_good` at 0, returning to idle once all outputs are low.
- R11: A `track_fault` pulse while sequencing, up, or tracking down starts the retry hold.
- R12: Loss of any `supply_ok` bit while sequencing or up, or loss of an included rail's `out_good` while up, starts the retry hold.
- R13: `gate_sink` and `out_drain` are active only in fast shutdown and retry hold, and never together with any gate on.
- R14: After reset the controller is idle with all outputs 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| supply_here | input | NUM_RAILS | Input supply present per rail (0 excludes the rail) |
| supply_ok | input | NUM_RAILS | Input supply above undervoltage level per rail |
| enable_hi | input | 1 | Enable line above rising threshold |
| enable_lo | input | 1 | Enable line below falling threshold |
| out_good | input | NUM_RAILS | Output above power-good level per rail |
| out_low | input | NUM_RAILS | Output below power-low level per rail |
| track_fault | input | 1 | Ramp tracker fault pulse |
| gate_on | output | NUM_RAILS | Gate drive enable per rail |
| gate_sink | output | NUM_RAILS | Strong gate pulldown per rail |
| out_drain | output | NUM_RAILS | Output discharge path per rail |
| power_good | output | 1 | All rails up and power-good timeout elapsed |

## Verification
The bench brings the block up under all eight presence masks. This shows that skipping is correct for every combination of excluded rails, that the gate order holds, and that each delay is measured from the right event. Each mask then ends through either the controlled track-down or a tracker fault, which separates the quiet shutdown from the discharging one. Directed runs remove one start condition at a time (an undervoltage bit, an output not yet low) to show that each one gates the start on its own. They let the fault timer expire and hold an output high across the retry to show that the restart waits for it. They drop the enable before and after power-good, and remove a supply mid-sequence, so that every entry into the retry hold and into fast shutdown is timed to the cycle.

// File: rtl/rail_seq_pkg.sv
`timescale 1ns/1ps
package rail_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START_DELAY,
        ST_RAMP_RAIL,
        ST_ALL_UP,
        ST_TRACK_DOWN,
        ST_FAST_SHUTDOWN,
        ST_RETRY_HOLD
    } seq_state_t;

endpackage

// File: rtl/rail_seq_sync.sv
`timescale 1ns/1ps
module rail_seq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    genvar b;
    generate
        for (b = 0; b < W; b++) begin : g_bit
            logic stage1;
            logic stage2;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stage1 <= 1'b0;
                    stage2 <= 1'b0;
                end else begin
                    stage1 <= d[b];
                    stage2 <= stage1;
                end
            end
            assign q[b] = stage2;
        end
    endgenerate

endmodule

// File: rtl/rail_seq_timer.sv
`timescale 1ns/1ps
module rail_seq_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          done
);

    logic [TW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/rail_seq_fsm.sv
`timescale 1ns/1ps
module rail_seq_fsm
    import rail_seq_pkg::*;
#(
    parameter int N     = 3,
    parameter int TW    = 8,
    parameter int D_CYC = 8,
    parameter int P_CYC = 12,
    parameter int R_CYC = 1280
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  here_s,
    input  logic [N-1:0]  ok_s,
    input  logic          hi_s,
    input  logic          lo_s,
    input  logic [N-1:0]  good_s,
    input  logic [N-1:0]  low_s,
    input  logic          tflt_s,
    input  logic          del_done,
    input  logic          flt_done,
    output logic          del_load,
    output logic [TW-1:0] del_val,
    output logic          flt_load,
    output logic [N-1:0]  gate_on,
    output logic [N-1:0]  gate_sink,
    output logic [N-1:0]  out_drain,
    output logic          power_good
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;
    localparam logic [TW-1:0] D_LD = TW'(D_CYC - 1);
    localparam logic [TW-1:0] P_LD = TW'(P_CYC - 1);
    localparam logic [TW-1:0] R_LD = TW'(R_CYC - 1);

    seq_state_t    st, st_nxt;
    logic [IW-1:0] idx, idx_nxt;

    // lowest included rail at or above 'from': {found, index}
    function automatic logic [IW:0] pick(input logic [N-1:0] m, input int from);
        logic [IW:0] r;
        r = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (i >= from && m[i]) r = {1'b1, IW'(i)};
        end
        return r;
    endfunction

    logic          start_ok;
    logic          all_low;
    logic          uv_all;
    logic          lost_good;
    logic          cur_good;
    logic [IW:0]   first_rail;
    logic [IW:0]   next_rail;

    always_comb begin
        uv_all     = &ok_s;
        start_ok   = hi_s && !lo_s && uv_all;
        all_low    = &(low_s | ~here_s);
        lost_good  = |(here_s & ~good_s);
        cur_good   = good_s[idx];
        first_rail = pick(here_s, 0);
        next_rail  = pick(here_s, int'(idx) + 1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            idx <= '0;
        end else begin
            st  <= st_nxt;
            idx <= idx_nxt;
        end
    end

    // next state and timer loads
    always_comb begin
        st_nxt   = st;
        idx_nxt  = idx;
        del_load = 1'b0;
        del_val  = '0;
        flt_load = 1'b0;
        unique case (st)
            ST_IDLE: begin
                if (start_ok && all_low) begin
                    flt_load = 1'b1;
                    del_load = 1'b1;
                    if (first_rail[IW]) begin
                        st_nxt  = ST_START_DELAY;
                        idx_nxt = first_rail[IW-1:0];
                        del_val = D_LD;
                    end else begin
                        st_nxt  = ST_ALL_UP;
                        del_val = P_LD;
                    end
                end
            end
            ST_START_DELAY, ST_RAMP_RAIL: begin
                if (tflt_s || !uv_all || flt_done) begin
                    st_nxt   = ST_RETRY_HOLD;
                    del_load = 1'b1;
                    del_val  = R_LD;
                end else if (lo_s) begin
                    st_nxt = ST_FAST_SHUTDOWN;
                end else if (st == ST_START_DELAY) begin
                    if (del_done) st_nxt = ST_RAMP_RAIL;
                end else if (cur_good) begin
                    del_load = 1'b1;
                    if (next_rail[IW]) begin
                        st_nxt  = ST_START_DELAY;
                        idx_nxt = next_rail[IW-1:0];
                        del_val = D_LD;
                    end else begin
                        st_nxt  = ST_ALL_UP;
                        del_val = P_LD;
                    end
                end
            end
            ST_ALL_UP: begin
                if (tflt_s || !uv_all || lost_good) begin
                    st_nxt   = ST_RETRY_HOLD;
                    del_load = 1'b1;
                    del_val  = R_LD;
                end else if (lo_s) begin
                    st_nxt = del_done ? ST_TRACK_DOWN : ST_FAST_SHUTDOWN;
                end
            end
            ST_TRACK_DOWN: begin
                if (tflt_s) begin
                    st_nxt   = ST_RETRY_HOLD;
                    del_load = 1'b1;
                    del_val  = R_LD;
                end else if (all_low) begin
                    st_nxt = ST_IDLE;
                end
            end
            ST_FAST_SHUTDOWN: begin
                if (all_low) st_nxt = ST_IDLE;
            end
            ST_RETRY_HOLD: begin
                if (del_done) st_nxt = ST_IDLE;
            end
            default: st_nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        gate_on    = '0;
        gate_sink  = '0;
        out_drain  = '0;
        power_good = 1'b0;
        unique case (st)
            ST_START_DELAY: begin
                for (int i = 0; i < N; i++) gate_on[i] = here_s[i] && (IW'(i) < idx);
            end
            ST_RAMP_RAIL: begin
                for (int i = 0; i < N; i++) gate_on[i] = here_s[i] && (IW'(i) <= idx);
            end
            ST_ALL_UP: begin
                gate_on    = here_s;
                power_good = del_done;
            end
            ST_FAST_SHUTDOWN, ST_RETRY_HOLD: begin
                gate_sink = '1;
                out_drain = '1;
            end
            default: begin
                gate_on = '0;
            end
        endcase
    end

endmodule

// File: rtl/rail_seq_ctrl.sv
`timescale 1ns/1ps
module rail_seq_ctrl #(
    parameter int NUM_RAILS   = 3,
    parameter int DELAY_CYC   = 20000,
    parameter int FAULT_CYC   = 2191000,
    parameter int PG_CYC      = 20000,
    parameter int RETRY_RATIO = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_RAILS-1:0] supply_here,
    input  logic [NUM_RAILS-1:0] supply_ok,
    input  logic                 enable_hi,
    input  logic                 enable_lo,
    input  logic [NUM_RAILS-1:0] out_good,
    input  logic [NUM_RAILS-1:0] out_low,
    input  logic                 track_fault,
    output logic [NUM_RAILS-1:0] gate_on,
    output logic [NUM_RAILS-1:0] gate_sink,
    output logic [NUM_RAILS-1:0] out_drain,
    output logic                 power_good
);

    localparam int N         = NUM_RAILS;
    localparam int RETRY_CYC = RETRY_RATIO * FAULT_CYC;
    localparam int M1        = (DELAY_CYC > PG_CYC) ? DELAY_CYC : PG_CYC;
    localparam int M2        = (FAULT_CYC > RETRY_CYC) ? FAULT_CYC : RETRY_CYC;
    localparam int MAXC      = (M1 > M2) ? M1 : M2;
    localparam int TW        = $clog2(MAXC + 1);
    localparam logic [TW-1:0] F_LD = TW'(FAULT_CYC - 1);
    localparam int SW        = 4 * N + 3;

    logic [N-1:0] here_s, ok_s, good_s, low_s;
    logic         hi_s, lo_s, tflt_s;
    logic         del_load, flt_load, del_done, flt_done;
    logic [TW-1:0] del_val;

    rail_seq_sync #(.W(SW)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({supply_here, supply_ok, out_good, out_low, enable_hi, enable_lo, track_fault}),
        .q     ({here_s, ok_s, good_s, low_s, hi_s, lo_s, tflt_s})
    );

    rail_seq_timer #(.TW(TW)) u_del_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (del_load),
        .load_val (del_val),
        .done     (del_done)
    );

    rail_seq_timer #(.TW(TW)) u_flt_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (flt_load),
        .load_val (F_LD),
        .done     (flt_done)
    );

    rail_seq_fsm #(
        .N     (N),
        .TW    (TW),
        .D_CYC (DELAY_CYC),
        .P_CYC (PG_CYC),
        .R_CYC (RETRY_CYC)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .here_s     (here_s),
        .ok_s       (ok_s),
        .hi_s       (hi_s),
        .lo_s       (lo_s),
        .good_s     (good_s),
        .low_s      (low_s),
        .tflt_s     (tflt_s),
        .del_done   (del_done),
        .flt_done   (flt_done),
        .del_load   (del_load),
        .del_val    (del_val),
        .flt_load   (flt_load),
        .gate_on    (gate_on),
        .gate_sink  (gate_sink),
        .out_drain  (out_drain),
        .power_good (power_good)
    );

endmodule

// File: rtl/rail_seq_chk.sv
`timescale 1ns/1ps
module rail_seq_chk #(
    parameter int N = 3
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] ok_s,
    input logic [N-1:0] here_s,
    input logic [N-1:0] gate_on,
    input logic [N-1:0] gate_sink,
    input logic [N-1:0] out_drain,
    input logic         power_good
);

    assert_start_needs_supplies_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|gate_on) |-> $past(&ok_s));

    assert_single_gate_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gate_on & ~$past(gate_on)));

    assert_pgood_all_on_R8: assert property (@(posedge clk) disable iff (!rst_n)
        power_good |-> (gate_on == here_s));

    assert_sink_gate_exclusive_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (gate_on & gate_sink) == '0);

    assert_drain_gates_off_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_drain) |-> (gate_on == '0));

endmodule

bind rail_seq_ctrl rail_seq_chk #(.N(NUM_RAILS)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ok_s       (ok_s),
    .here_s     (here_s),
    .gate_on    (gate_on),
    .gate_sink  (gate_sink),
    .out_drain  (out_drain),
    .power_good (power_good)
);

// File: tb/rail_seq_ctrl_test.sv
`timescale 1ns/1ps
module rail_seq_ctrl_test;

    localparam int D = 8;
    localparam int F = 80;
    localparam int P = 12;
    localparam int R = 16 * F;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [2:0] supply_here, supply_ok, out_good, out_low;
    logic       enable_hi, enable_lo, track_fault;
    logic [2:0] gate_on, gate_sink, out_drain;
    logic       power_good;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rail_seq_ctrl #(
        .NUM_RAILS   (3),
        .DELAY_CYC   (D),
        .FAULT_CYC   (F),
        .PG_CYC      (P),
        .RETRY_RATIO (16)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .supply_here (supply_here),
        .supply_ok   (supply_ok),
        .enable_hi   (enable_hi),
        .enable_lo   (enable_lo),
        .out_good    (out_good),
        .out_low     (out_low),
        .track_fault (track_fault),
        .gate_on     (gate_on),
        .gate_sink   (gate_sink),
        .out_drain   (out_drain),
        .power_good  (power_good)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic probe(input int sel);
        case (sel)
            0, 1, 2: return gate_on[sel];
            3:       return |out_drain;
            4:       return power_good;
            6:       return |gate_sink;
            default: return |gate_on;
        endcase
    endfunction

    // edges counted until probe(sel)==val, sampled at falling edges
    task automatic meas(input int sel, input logic val, input int lim, output int n);
        n = 0;
        while (1) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (probe(sel) == val) return;
            if (n >= lim) begin
                n = -1;
                return;
            end
        end
    endtask

    task automatic init(input logic [2:0] mask);
        rst_n       = 1'b0;
        supply_here = mask;
        supply_ok   = 3'b111;
        enable_hi   = 1'b0;
        enable_lo   = 1'b1;
        out_good    = 3'b000;
        out_low     = 3'b111;
        track_fault = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic bring_up(input logic [2:0] mask, input bit wait_pg);
        int n;
        enable_hi = 1'b1;
        enable_lo = 1'b0;
        for (int i = 0; i < 3; i++) begin
            if (mask[i]) begin
                meas(i, 1'b1, 200, n);
                if (i == 0 || (mask & 3'((1 << i) - 1)) == 3'b000) chk("R3 delay before first rail", n, D + 3);
                else chk("R4 delay after previous good", n, D + 3);
                chk("R2 gates on in order", int'(gate_on), int'(mask & 3'((2 << i) - 1)));
                out_good[i] = 1'b1;
                out_low[i]  = 1'b0;
            end
        end
        if (wait_pg) begin
            meas(4, 1'b1, 200, n);
            chk("R8 power good timeout", n, P + 2);
            chk("R5 only included gates on", int'(gate_on), int'(mask));
        end
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;

        // R14 reset state
        init(3'b111);
        chk("R14 gates after reset", int'(gate_on), 0);
        chk("R14 sink after reset", int'(gate_sink), 0);
        chk("R14 drain after reset", int'(out_drain), 0);
        chk("R14 power good after reset", int'(power_good), 0);

        // sweep over every presence mask
        for (int m = 0; m < 8; m++) begin
            init(3'(m));
            bring_up(3'(m), 1'b1);
            if (m[0]) begin
                enable_hi = 1'b0;
                enable_lo = 1'b1;
                meas(7, 1'b0, 50, n);
                chk("R10 track down gates off", n, 3);
                chk("R10 track down no sink", int'(gate_sink), 0);
                chk("R10 track down no drain", int'(out_drain), 0);
                chk("R10 track down power good low", int'(power_good), 0);
                out_good = 3'b000;
                out_low  = 3'b111;
                repeat (5) @(negedge clk);
                chk("R10 idle after outputs low", int'(gate_sink | out_drain | gate_on), 0);
            end else begin
                track_fault = 1'b1;
                @(posedge clk);
                @(negedge clk);
                track_fault = 1'b0;
                meas(3, 1'b1, 50, n);
                chk("R11 tracker fault to retry", n, 2);
                chk("R13 gates off in retry", int'(gate_on), 0);
            end
        end

        // R1 start blocked by an undervoltage bit
        init(3'b111);
        supply_ok = 3'b011;
        enable_hi = 1'b1;
        enable_lo = 1'b0;
        repeat (40) @(negedge clk);
        chk("R1 no start with supply low", int'(gate_on), 0);
        supply_ok = 3'b111;
        meas(0, 1'b1, 100, n);
        chk("R1 start after supply ok", n, D + 3);

        // R1 start blocked by an output not low
        init(3'b111);
        out_low   = 3'b101;
        enable_hi = 1'b1;
        enable_lo = 1'b0;
        repeat (40) @(negedge clk);
        chk("R1 no start with output high", int'(gate_on), 0);
        out_low = 3'b111;
        meas(0, 1'b1, 100, n);
        chk("R1 start after outputs low", n, D + 3);

        // R6/R7 fault timeout and retry
        init(3'b111);
        enable_hi = 1'b1;
        enable_lo = 1'b0;
        meas(3, 1'b1, 400, n);
        chk("R6 fault timeout", n, F + 3);
        chk("R6 gates forced off", int'(gate_on), 0);
        chk("R7 sink in retry", int'(gate_sink), 7);
        meas(3, 1'b0, R + 50, n);
        chk("R7 retry hold length", n, R);
        meas(0, 1'b1, 200, n);
        chk("R7 restart after retry", n, D + 1);

        // R7 restart waits for outputs low
        init(3'b111);
        enable_hi = 1'b1;
        enable_lo = 1'b0;
        meas(3, 1'b1, 400, n);
        out_low[1] = 1'b0;
        meas(3, 1'b0, R + 50, n);
        chk("R7 retry hold length again", n, R);
        repeat (40) @(negedge clk);
        chk("R7 no restart while output high", int'(gate_on), 0);
        out_low = 3'b111;
        meas(0, 1'b1, 200, n);
        chk("R7 restart once outputs low", n, D + 3);

        // R9 enable drop before power good
        init(3'b111);
        bring_up(3'b111, 1'b0);
        repeat (4) @(negedge clk);
        chk("R9 not yet power good", int'(power_good), 0);
        enable_hi = 1'b0;
        enable_lo = 1'b1;
        meas(6, 1'b1, 50, n);
        chk("R9 fast shutdown entry", n, 3);
        chk("R9 drain in fast shutdown", int'(out_drain), 7);
        chk("R9 gates off in fast shutdown", int'(gate_on), 0);
        out_good = 3'b000;
        out_low  = 3'b111;
        meas(6, 1'b0, 50, n);
        chk("R9 idle after outputs low", n, 3);
        chk("R13 drain released in idle", int'(out_drain), 0);

        // R12 supply loss mid-sequence
        init(3'b111);
        enable_hi = 1'b1;
        enable_lo = 1'b0;
        meas(0, 1'b1, 100, n);
        out_good[0] = 1'b1;
        out_low[0]  = 1'b0;
        repeat (2) @(negedge clk);
        supply_ok[2] = 1'b0;
        meas(3, 1'b1, 50, n);
        chk("R12 supply loss to retry", n, 3);
        chk("R12 gates off", int'(gate_on), 0);

        // R12 output loses good while up
        init(3'b011);
        bring_up(3'b011, 1'b1);
        out_good[1] = 1'b0;
        meas(3, 1'b1, 50, n);
        chk("R12 good loss to retry", n, 3);
        chk("R12 power good dropped", int'(power_good), 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule